// File: doc/BRIEF.md
# Cache Master Valid Bit Array

This block holds one master valid bit for every eight cache lines and combines it with the per-line valid bit read from an ordinary, non-resettable valid RAM. A line counts as valid only when both its RAM bit and the master bit of its eight-line group are set. Clearing the whole master bank in one clock edge therefore invalidates the entire cache in a single cycle. The valid RAM can then be built from plain cells that need no reset.

A line fill sets the master bit of the filled line's group. When that group was previously invalid, the block asks the valid RAM controller to clear the other seven lines of the group. This stops stale RAM bits from reappearing as valid lines.

A system-coprocessor register port exposes the master bits as 32-bit registers, so software can save them before a dormant low-power state and restore them afterwards. Only privileged accesses are accepted. A user-mode access raises an undefined-instruction indication. The cache size and the coprocessor bank selector are parameters, so one instance serves each cache.

Top module: `mv_inval_array`

## Requirements
- R1: After reset every master bit is 0, `cp_ack`, `cp_undef` and `ram_clr_req` are low and `cp_rdata` is 0.
- R2: `line_valid` is combinationally `ram_valid` AND the master bit of group `line_idx[LINE_W-1:3]`; `line_idx[2:0]` is the line's position inside its group.
- R3: A `fill` sets the master bit of the filled line's group at the next clock edge.
- R4: A `fill` into a group whose master bit is clear raises `ram_clr_req` for one cycle after the edge. In that cycle `ram_clr_group` is the group and `ram_clr_keep` is the filled line's offset. A fill into a group that is already valid raises no request.
- R5: `inval_all` clears every master bit at the next edge. It overrides a fill or a register write in the same cycle, and it suppresses the clear request.
- R6: A register access is decoded only when `cp_op1`=3, `cp_crn`=15 and `cp_crm`=`BANK_CRM`. The values 8 (instruction cache), 12 (data cache) and 10 or 14 (auxiliary caches) are the intended settings. Any other access gets no `cp_ack` and no `cp_undef`, and changes no master bit.
- R7: Register n bit b holds the master bit of group 32*n+b. `cp_op2` gives n, and registers are numbered upward from 0.
- R8: A privileged read raises `cp_ack` one cycle after the request, with the register contents on `cp_rdata`. A privileged write raises `cp_ack` and updates the register at the request's clock edge.
- R9: A user-mode access (`cp_priv`=0) raises `cp_undef` one cycle later without `cp_ack`, returns 0 on `cp_rdata` and changes no master bit.
- R10: Bits and registers beyond the implemented group count read as 0, and writes to them are ignored.
- R11: When a fill and a privileged write to the same register happen in one cycle, the filled group's bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_idx | input | LINE_W | Cache line index, used for lookup and for fill |
| ram_valid | input | 1 | Raw valid bit read from the valid RAM for `line_idx` |
| fill | input | 1 | Line-fill strobe for `line_idx` |
| inval_all | input | 1 | Invalidate-all strobe |
| line_valid | output | 1 | Effective valid of `line_idx` |
| ram_clr_req | output | 1 | Request to clear the rest of a newly opened group |
| ram_clr_group | output | GRP_W | Group to clear |
| ram_clr_keep | output | 3 | Line offset in the group that must be kept |
| cp_req | input | 1 | Coprocessor access strobe |
| cp_write | input | 1 | 1 for write, 0 for read |
| cp_priv | input | 1 | 1 when the access is privileged |
| cp_op1 | input | 3 | First opcode field |
| cp_crn | input | 4 | Primary register field |
| cp_crm | input | 4 | Secondary register field, selects the bank |
| cp_op2 | input | 3 | Register number |
| cp_wdata | input | 32 | Write data |
| cp_rdata | output | 32 | Read data, one cycle after the request |
| cp_ack | output | 1 | Access accepted, one cycle after the request |
| cp_undef | output | 1 | Undefined-instruction indication for user access |

## Verification
The bench targets the group boundaries. Lines 0x12 and 0x1A sit on either side of a group edge, so a design that shifts the index wrongly would report the wrong line as valid. It also checks that group 40 lands in bit 8 of register 1; a packing mistake would move that bit into the wrong register or the wrong position. Collisions get their own cases: an invalidate-all arriving with a fill or a write must leave every bit clear, and a fill arriving with a clearing write must keep its bit. A design with the wrong priority would leave stale bits or lose the fill. Further cases cover user-mode writes, near-miss decodes, and writes to unimplemented registers. A design that leaks any of these would corrupt saved state, and the bench catches that by reading the registers back.

// File: rtl/mv_pkg.sv
package mv_pkg;
    localparam int REG_W     = 32;
    localparam int MAX_REGS  = 8;
    localparam int GRP_LINES = 8;
    localparam int OFS_W     = 3;
    localparam int PAD_W     = REG_W * MAX_REGS;

    localparam logic [2:0] OP1_SEL = 3'd3;
    localparam logic [3:0] CRN_SEL = 4'd15;

    typedef enum logic [1:0] {
        CP_IDLE  = 2'd0,
        CP_READ  = 2'd1,
        CP_WRITE = 2'd2,
        CP_FAULT = 2'd3
    } cp_kind_e;

    typedef struct packed {
        cp_kind_e          kind;
        logic [2:0]        idx;
        logic [REG_W-1:0]  wdata;
    } cp_cmd_t;

    function automatic int groups_for(input int kbytes, input int line_bytes);
        return (kbytes * 1024) / line_bytes / GRP_LINES;
    endfunction

    function automatic int regs_for(input int groups);
        return (groups + REG_W - 1) / REG_W;
    endfunction
endpackage

// File: rtl/mv_cp_decode.sv
module mv_cp_decode
    import mv_pkg::*;
#(
    parameter logic [3:0] BANK_CRM = 4'd12
) (
    input  logic        req,
    input  logic        write,
    input  logic        priv,
    input  logic [2:0]  op1,
    input  logic [3:0]  crn,
    input  logic [3:0]  crm,
    input  logic [2:0]  op2,
    input  logic [31:0] wdata,
    output cp_cmd_t     cmd
);
    logic match;

    always_comb begin
        match     = req && (op1 == OP1_SEL) && (crn == CRN_SEL) && (crm == BANK_CRM);
        cmd.idx   = op2;
        cmd.wdata = wdata;
        if (!match)      cmd.kind = CP_IDLE;
        else if (!priv)  cmd.kind = CP_FAULT;
        else if (write)  cmd.kind = CP_WRITE;
        else             cmd.kind = CP_READ;
    end
endmodule

// File: rtl/mv_master_bank.sv
module mv_master_bank
    import mv_pkg::*;
#(
    parameter int GROUPS   = 64,
    parameter int NUM_REGS = 2,
    parameter int GRP_W    = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill,
    input  logic [GRP_W-1:0]  fill_grp,
    input  logic [OFS_W-1:0]  fill_ofs,
    input  logic              inval,
    input  cp_cmd_t           cmd,
    output logic [GROUPS-1:0] master,
    output logic              clr_req,
    output logic [GRP_W-1:0]  clr_grp,
    output logic [OFS_W-1:0]  clr_keep,
    output logic [REG_W-1:0]  rdata,
    output logic              ack,
    output logic              undef
);
    logic [GROUPS-1:0] master_nx;
    logic [PAD_W-1:0]  padded;
    logic              open_grp;

    always_comb begin
        padded = '0;
        padded[GROUPS-1:0] = master;
    end

    always_comb begin
        master_nx = master;
        if (cmd.kind == CP_WRITE) begin
            for (int g = 0; g < GROUPS; g++) begin
                if (int'(cmd.idx) == g / REG_W)
                    master_nx[g] = cmd.wdata[g % REG_W];
            end
        end
        if (fill)
            master_nx[fill_grp] = 1'b1;
        if (inval)
            master_nx = '0;
    end

    assign open_grp = fill && !inval && !master[fill_grp];

    always_ff @(posedge clk) begin
        if (rst) begin
            master   <= '0;
            clr_req  <= 1'b0;
            clr_grp  <= '0;
            clr_keep <= '0;
            rdata    <= '0;
            ack      <= 1'b0;
            undef    <= 1'b0;
        end else begin
            master   <= master_nx;
            clr_req  <= open_grp;
            clr_grp  <= fill_grp;
            clr_keep <= fill_ofs;
            ack      <= (cmd.kind == CP_READ) || (cmd.kind == CP_WRITE);
            undef    <= (cmd.kind == CP_FAULT);
            rdata    <= (cmd.kind == CP_READ) ? padded[{cmd.idx, 5'b0} +: REG_W] : '0;
        end
    end

    assert_fill_sets_R3: assert property (@(posedge clk) disable iff (rst)
        (fill && !inval) |=> master[$past(fill_grp)]);

    assert_clr_group_open_R4: assert property (@(posedge clk) disable iff (rst)
        clr_req |-> master[clr_grp]);

    assert_inval_clears_R5: assert property (@(posedge clk) disable iff (rst)
        inval |=> (master == '0));

    assert_user_no_change_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd.kind == CP_FAULT && !fill && !inval) |=> $stable(master));

    assert_ack_undef_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(ack && undef));

    assert_unimpl_reads_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd.kind == CP_READ && int'(cmd.idx) >= NUM_REGS) |=> (rdata == '0));
endmodule

// File: rtl/mv_inval_array.sv
module mv_inval_array
    import mv_pkg::*;
#(
    parameter int         CACHE_KB   = 16,
    parameter int         LINE_BYTES = 32,
    parameter logic [3:0] BANK_CRM   = 4'd12,
    localparam int        GROUPS     = groups_for(CACHE_KB, LINE_BYTES),
    localparam int        NUM_REGS   = regs_for(GROUPS),
    localparam int        GRP_W      = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int        LINE_W     = GRP_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] line_idx,
    input  logic              ram_valid,
    input  logic              fill,
    input  logic              inval_all,
    output logic              line_valid,
    output logic              ram_clr_req,
    output logic [GRP_W-1:0]  ram_clr_group,
    output logic [2:0]        ram_clr_keep,
    input  logic              cp_req,
    input  logic              cp_write,
    input  logic              cp_priv,
    input  logic [2:0]        cp_op1,
    input  logic [3:0]        cp_crn,
    input  logic [3:0]        cp_crm,
    input  logic [2:0]        cp_op2,
    input  logic [31:0]       cp_wdata,
    output logic [31:0]       cp_rdata,
    output logic              cp_ack,
    output logic              cp_undef
);
    cp_cmd_t           cmd;
    logic [GROUPS-1:0] master;
    logic [GRP_W-1:0]  grp;

    assign grp        = line_idx[LINE_W-1:OFS_W];
    assign line_valid = ram_valid && master[grp];

    mv_cp_decode #(.BANK_CRM(BANK_CRM)) u_dec (
        .req(cp_req), .write(cp_write), .priv(cp_priv),
        .op1(cp_op1), .crn(cp_crn), .crm(cp_crm), .op2(cp_op2),
        .wdata(cp_wdata), .cmd(cmd)
    );

    mv_master_bank #(.GROUPS(GROUPS), .NUM_REGS(NUM_REGS), .GRP_W(GRP_W)) u_bank (
        .clk(clk), .rst(rst),
        .fill(fill), .fill_grp(grp), .fill_ofs(line_idx[OFS_W-1:0]),
        .inval(inval_all), .cmd(cmd), .master(master),
        .clr_req(ram_clr_req), .clr_grp(ram_clr_group), .clr_keep(ram_clr_keep),
        .rdata(cp_rdata), .ack(cp_ack), .undef(cp_undef)
    );

    assert_line_gated_R2: assert property (@(posedge clk) disable iff (rst)
        line_valid |-> ram_valid);
endmodule

// File: tb/mv_inval_array_bench.sv
module mv_inval_array_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [8:0]  line_idx;
    logic        ram_valid, fill, inval_all;
    logic        line_valid, ram_clr_req;
    logic [5:0]  ram_clr_group;
    logic [2:0]  ram_clr_keep;
    logic        cp_req, cp_write, cp_priv;
    logic [2:0]  cp_op1, cp_op2;
    logic [3:0]  cp_crn, cp_crm;
    logic [31:0] cp_wdata, cp_rdata;
    logic        cp_ack, cp_undef;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    mv_inval_array #(.CACHE_KB(16), .LINE_BYTES(32), .BANK_CRM(4'd12)) u_mv_inval_array (
        .clk(clk), .rst(rst), .line_idx(line_idx), .ram_valid(ram_valid),
        .fill(fill), .inval_all(inval_all), .line_valid(line_valid),
        .ram_clr_req(ram_clr_req), .ram_clr_group(ram_clr_group), .ram_clr_keep(ram_clr_keep),
        .cp_req(cp_req), .cp_write(cp_write), .cp_priv(cp_priv), .cp_op1(cp_op1),
        .cp_crn(cp_crn), .cp_crm(cp_crm), .cp_op2(cp_op2), .cp_wdata(cp_wdata),
        .cp_rdata(cp_rdata), .cp_ack(cp_ack), .cp_undef(cp_undef)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cp(input logic wr, input logic pv, input logic [2:0] op1,
                      input logic [3:0] crn, input logic [3:0] crm, input logic [2:0] op2,
                      input logic [31:0] wd, output logic ack, output logic und,
                      output logic [31:0] rd);
        cp_req = 1'b1; cp_write = wr; cp_priv = pv; cp_op1 = op1;
        cp_crn = crn; cp_crm = crm; cp_op2 = op2; cp_wdata = wd;
        @(negedge clk);
        ack = cp_ack; und = cp_undef; rd = cp_rdata;
        cp_req = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] n, input logic [31:0] exp, input string req);
        logic a, u; logic [31:0] d;
        cp(1'b0, 1'b1, 3'd3, 4'd15, 4'd12, n, 32'h0, a, u, d);
        chk({req, " read ack"}, {31'b0, a}, 32'd1);
        chk({req, " read data"}, d, exp);
    endtask

    task automatic wr_reg(input logic [2:0] n, input logic [31:0] v);
        logic a, u; logic [31:0] d;
        cp(1'b1, 1'b1, 3'd3, 4'd15, 4'd12, n, v, a, u, d);
        chk("R8 write ack", {31'b0, a}, 32'd1);
    endtask

    task automatic look(input logic [8:0] idx, input logic rv, input logic exp, input string req);
        line_idx = idx; ram_valid = rv;
        #1;
        chk(req, {31'b0, line_valid}, {31'b0, exp});
        ram_valid = 1'b0;
    endtask

    task automatic do_fill(input logic [8:0] idx, input logic exp_req);
        line_idx = idx; fill = 1'b1;
        @(negedge clk);
        fill = 1'b0;
        chk("R4 clear request", {31'b0, ram_clr_req}, {31'b0, exp_req});
        if (exp_req) begin
            chk("R4 clear group", {26'b0, ram_clr_group}, {26'b0, idx[8:3]});
            chk("R4 keep offset", {29'b0, ram_clr_keep}, {29'b0, idx[2:0]});
        end
    endtask

    task automatic t_reset;
        chk("R1 ack low", {31'b0, cp_ack}, 32'd0);
        chk("R1 undef low", {31'b0, cp_undef}, 32'd0);
        chk("R1 clr low", {31'b0, ram_clr_req}, 32'd0);
        chk("R1 rdata zero", cp_rdata, 32'd0);
        look(9'h012, 1'b1, 1'b0, "R1 master clear gates line");
        rd_reg(3'd0, 32'h0, "R1 reg0");
        rd_reg(3'd1, 32'h0, "R1 reg1");
    endtask

    task automatic t_fill;
        do_fill(9'h015, 1'b1);
        look(9'h012, 1'b1, 1'b1, "R3 group 2 valid");
        look(9'h012, 1'b0, 1'b0, "R2 ram bit low masks");
        look(9'h01A, 1'b1, 1'b0, "R2 group 3 still invalid");
        do_fill(9'h013, 1'b0);
    endtask

    task automatic t_map;
        do_fill(9'd321, 1'b1);
        rd_reg(3'd1, 32'h0000_0100, "R7 group 40 in reg1 bit8");
        rd_reg(3'd0, 32'h0000_0004, "R7 group 2 in reg0 bit2");
    endtask

    task automatic t_write;
        wr_reg(3'd0, 32'hA5A5_0000);
        rd_reg(3'd0, 32'hA5A5_0000, "R8 readback");
        look(9'd128, 1'b1, 1'b1, "R8 written bit 16 gates line");
        look(9'd136, 1'b1, 1'b0, "R8 written bit 17 clear");
    endtask

    task automatic t_user;
        logic a, u; logic [31:0] d;
        cp(1'b1, 1'b0, 3'd3, 4'd15, 4'd12, 3'd0, 32'hFFFF_FFFF, a, u, d);
        chk("R9 user write undef", {31'b0, u}, 32'd1);
        chk("R9 user write no ack", {31'b0, a}, 32'd0);
        cp(1'b0, 1'b0, 3'd3, 4'd15, 4'd12, 3'd0, 32'h0, a, u, d);
        chk("R9 user read undef", {31'b0, u}, 32'd1);
        chk("R9 user read data zero", d, 32'd0);
        rd_reg(3'd0, 32'hA5A5_0000, "R9 state unchanged");
    endtask

    task automatic t_decode;
        logic a, u; logic [31:0] d;
        cp(1'b1, 1'b1, 3'd3, 4'd15, 4'd8, 3'd0, 32'h0, a, u, d);
        chk("R6 other bank crm no ack", {30'b0, a, u}, 32'd0);
        cp(1'b1, 1'b1, 3'd5, 4'd15, 4'd12, 3'd0, 32'h0, a, u, d);
        chk("R6 op1 mismatch no ack", {30'b0, a, u}, 32'd0);
        cp(1'b1, 1'b1, 3'd3, 4'd14, 4'd12, 3'd0, 32'h0, a, u, d);
        chk("R6 crn mismatch no ack", {30'b0, a, u}, 32'd0);
        rd_reg(3'd0, 32'hA5A5_0000, "R6 state unchanged");
    endtask

    task automatic t_unimpl;
        wr_reg(3'd5, 32'hFFFF_FFFF);
        rd_reg(3'd5, 32'h0, "R10 unimplemented reg reads 0");
        rd_reg(3'd0, 32'hA5A5_0000, "R10 reg0 untouched");
        rd_reg(3'd1, 32'h0000_0100, "R10 reg1 untouched");
    endtask

    task automatic t_fill_write;
        line_idx = 9'h015; fill = 1'b1;
        wr_reg(3'd0, 32'h0);
        fill = 1'b0;
        rd_reg(3'd0, 32'h0000_0004, "R11 fill beats write");
    endtask

    task automatic t_inval;
        logic a, u; logic [31:0] d;
        line_idx = 9'h02B; fill = 1'b1; inval_all = 1'b1;
        cp(1'b1, 1'b1, 3'd3, 4'd15, 4'd12, 3'd0, 32'hFFFF_FFFF, a, u, d);
        fill = 1'b0; inval_all = 1'b0;
        chk("R5 no clear request", {31'b0, ram_clr_req}, 32'd0);
        rd_reg(3'd0, 32'h0, "R5 reg0 cleared");
        rd_reg(3'd1, 32'h0, "R5 reg1 cleared");
        look(9'h012, 1'b1, 1'b0, "R5 line invalid after invalidate");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; line_idx = '0; ram_valid = 1'b0; fill = 1'b0; inval_all = 1'b0;
        cp_req = 1'b0; cp_write = 1'b0; cp_priv = 1'b0; cp_op1 = '0; cp_op2 = '0;
        cp_crn = '0; cp_crm = '0; cp_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_fill;
        t_map;
        t_write;
        t_user;
        t_decode;
        t_unimpl;
        t_fill_write;
        t_inval;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule